// File: doc/BRIEF.md
# Banked Asynchronous Memory Read Controller

This block sits on the host side of a group of slow, asynchronous, read-only memory banks whose data pins share one bus. A host issues a word address with a one-cycle request. The controller splits the address into a bank number and a row. The bank number drives one active-low chip select per bank. The row goes to the shared address pins. A single output-enable line, common to every bank, serves as the system read strobe. When the data has settled, the controller registers it and returns it with a one-cycle valid pulse.

All device timing is specified in nanoseconds and turned into wait states at elaboration, using the ceiling of each time divided by the clock period. The output enable is timed to fall late in the access, so that the enable window and the address window end on the same clock edge. Data is captured on that edge, before the address is allowed to move. After a read, the chip select of the bank just used stays low. A further read to that bank only restarts the address wait. A read to another bank first drops every chip select and waits out the bus-release time, so that two banks never drive the bus at the same time.

Top module: `mbank_rd_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every bit of `mem_ce_n` is 1, `mem_oe_n` is 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: The bank number is the top `BANK_W` bits of `req_addr`. `mem_addr` carries the low `ADDR_W-BANK_W` bits. At most one `mem_ce_n` bit is 0, and that bit is the one whose index equals the bank number.
- R3: `mem_oe_n` is 0 only while some bit of `mem_ce_n` is 0.
- R4: For the first read after reset, or a read to the bank that was read last, `rd_valid` rises exactly ACC cycles after the accept cycle, where ACC = ceil(T_ACC_NS*1000/CLK_PS). With the defaults ACC is 25. `rd_valid` lasts one cycle, and `rd_data` holds the value that `mem_dq` carried on the capture edge.
- R5: Before each capture, `mem_oe_n` is 0 for exactly OE = ceil(T_OE_NS*1000/CLK_PS) consecutive cycles (13 with the defaults). It is back at 1 in the cycle where `rd_valid` is 1.
- R6: A read to the bank that was read last keeps that bank's chip select at 0 throughout, and the select also stays at 0 while the controller is idle.
- R7: A read to a different bank holds every chip select at 1 for REL = ceil(T_REL_NS*1000/CLK_PS) cycles (12 with the defaults) before the new select falls. Its `rd_valid` comes REL+ACC cycles after the accept cycle.
- R8: `req_ready` is 0 from the cycle after an accept until `rd_valid`. A `req_valid` raised in that period is ignored: it does not change `mem_addr` or `mem_ce_n`, and it adds no `rd_valid`.
- R9: While `mem_oe_n` stays 0, `mem_addr` and `mem_ce_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request, accepted when `req_ready` is 1 |
| req_addr | input | ADDR_W | Word address: bank in the top bits, row below |
| req_ready | output | 1 | Controller idle and able to accept |
| rd_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W-BANK_W | Shared row address to all banks |
| mem_ce_n | output | 2**BANK_W | Active-low chip select, one per bank |
| mem_oe_n | output | 1 | Shared active-low output enable (read strobe) |
| mem_dq | input | DATA_W | Shared data bus from the banks |

## Verification
The hardest case to reach from the ports is a timing fault that still returns plausible data. Examples are an output enable that falls a few cycles early, or a bank switch that skips the release gap. The bench therefore models the memory with real time. The model returns the correct word only when the chip select, the address and the output enable have each been settled long enough. Otherwise it returns a poison value. The bench also measures the all-deselected gap at every bank change. Sequences alternate same-bank and cross-bank reads, and a burst of requests is issued while the controller is busy.

// File: rtl/mbrc_pkg.sv
`timescale 1ns/1ps
package mbrc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REL  = 2'd1,
      ST_ACC  = 2'd2
   } mbrc_state_e;

   // Wait states covering a nanosecond delay, never fewer than one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ps);
      int unsigned c;
      c = (ns * 1000 + per_ps - 1) / per_ps;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/mbrc_wait_cnt.sv
`timescale 1ns/1ps
module mbrc_wait_cnt #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/mbrc_bank_sel.sv
`timescale 1ns/1ps
module mbrc_bank_sel #(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned NBANK  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_d,
   input  logic [BANK_W-1:0] bank_d,
   output logic [NBANK-1:0]  ce_n
);

   logic [NBANK-1:0] hit;

   for (genvar i = 0; i < NBANK; i++) begin : g_dec
      assign hit[i] = en_d && (bank_d == BANK_W'(i));
   end

   // Registered so the select pins cannot glitch during decode.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n <= '1;
      end else begin
         ce_n <= ~hit;
      end
   end

endmodule

// File: rtl/mbrc_rd_capture.sv
`timescale 1ns/1ps
module mbrc_rd_capture #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap;
         if (cap) begin
            rd_data <= dq_in;
         end
      end
   end

endmodule

// File: rtl/mbank_rd_ctrl.sv
`timescale 1ns/1ps
module mbank_rd_ctrl
   import mbrc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned BANK_W   = 2,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CLK_PS   = 4000,
   parameter int unsigned T_ACC_NS = 100,
   parameter int unsigned T_OE_NS  = 50,
   parameter int unsigned T_REL_NS = 45
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       req_ready,
   output logic                       rd_valid,
   output logic [DATA_W-1:0]          rd_data,
   output logic [ADDR_W-BANK_W-1:0]   mem_addr,
   output logic [(2**BANK_W)-1:0]     mem_ce_n,
   output logic                       mem_oe_n,
   input  logic [DATA_W-1:0]          mem_dq
);

   localparam int unsigned NBANK    = 2 ** BANK_W;
   localparam int unsigned ROW_W    = ADDR_W - BANK_W;
   localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_PS);
   localparam int unsigned OE_CYC   = ns_to_cyc(T_OE_NS, CLK_PS);
   localparam int unsigned REL_CYC  = ns_to_cyc(T_REL_NS, CLK_PS);
   localparam int unsigned WAIT_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
   localparam int unsigned OE_LEAD  = WAIT_CYC - OE_CYC;
   localparam int unsigned MAX_CYC  = (WAIT_CYC > REL_CYC) ? WAIT_CYC : REL_CYC;
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] REL_LD  = CNT_W'(REL_CYC - 1);
   localparam logic [CNT_W-1:0] OE_MARK = CNT_W'(OE_CYC);
   localparam logic OE_AT_START = (OE_LEAD == 0);

   // elaboration-time parameter checks
   if (BANK_W < 1 || BANK_W >= ADDR_W) begin : g_bad_bank
      $error("mbank_rd_ctrl: BANK_W must be in 1..ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("mbank_rd_ctrl: DATA_W must be positive");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("mbank_rd_ctrl: CLK_PS must be positive");
   end

   mbrc_state_e        st_q, st_d;
   logic               open_q, open_d;
   logic [BANK_W-1:0]  bank_q, bank_d;
   logic [ROW_W-1:0]   row_q, row_d;
   logic               oe_n_q, oe_n_d;
   logic               t_load;
   logic [CNT_W-1:0]   t_load_val;
   logic [CNT_W-1:0]   t_cnt;
   logic               t_done;
   logic               cap;
   logic               oe_go;
   logic [BANK_W-1:0]  req_bank;
   logic [ROW_W-1:0]   req_row;

   assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
   assign req_row  = req_addr[ROW_W-1:0];

   mbrc_wait_cnt #(.CNT_W(CNT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_load_val),
      .cnt      (t_cnt),
      .done     (t_done)
   );

   // Output-enable placement: late in the access, or from its start.
   if (OE_LEAD > 0) begin : g_oe_late
      assign oe_go = (st_q == ST_ACC) && (t_cnt == OE_MARK);
   end else begin : g_oe_start
      assign oe_go = 1'b0;
   end

   always_comb begin
      st_d       = st_q;
      open_d     = open_q;
      bank_d     = bank_q;
      row_d      = row_q;
      oe_n_d     = oe_n_q;
      t_load     = 1'b0;
      t_load_val = WAIT_LD;
      cap        = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               bank_d = req_bank;
               row_d  = req_row;
               t_load = 1'b1;
               if (open_q && (req_bank != bank_q)) begin
                  st_d       = ST_REL;
                  open_d     = 1'b0;
                  t_load_val = REL_LD;
               end else begin
                  st_d   = ST_ACC;
                  open_d = 1'b1;
                  oe_n_d = ~OE_AT_START;
               end
            end
         end
         ST_REL: begin
            if (t_done) begin
               st_d   = ST_ACC;
               open_d = 1'b1;
               t_load = 1'b1;
               oe_n_d = ~OE_AT_START;
            end
         end
         ST_ACC: begin
            if (t_done) begin
               cap    = 1'b1;
               oe_n_d = 1'b1;
               st_d   = ST_IDLE;
            end else if (oe_go) begin
               oe_n_d = 1'b0;
            end
         end
         default: begin
            st_d   = ST_IDLE;
            open_d = 1'b0;
            oe_n_d = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         open_q <= 1'b0;
         bank_q <= '0;
         row_q  <= '0;
         oe_n_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         open_q <= open_d;
         bank_q <= bank_d;
         row_q  <= row_d;
         oe_n_q <= oe_n_d;
      end
   end

   mbrc_bank_sel #(.BANK_W(BANK_W), .NBANK(NBANK)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_d   (open_d),
      .bank_d (bank_d),
      .ce_n   (mem_ce_n)
   );

   mbrc_rd_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .dq_in    (mem_dq),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign req_ready = (st_q == ST_IDLE);
   assign mem_addr  = row_q;
   assign mem_oe_n  = oe_n_q;

endmodule

// File: rtl/mbank_rd_ctrl_chk.sv
`timescale 1ns/1ps
module mbank_rd_ctrl_chk
   import mbrc_pkg::*;
#(
   parameter int unsigned NBANK    = 4,
   parameter int unsigned ROW_W    = 8,
   parameter int unsigned CLK_PS   = 4000,
   parameter int unsigned T_REL_NS = 45
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rd_valid,
   input logic [ROW_W-1:0] mem_addr,
   input logic [NBANK-1:0] mem_ce_n,
   input logic             mem_oe_n
);

   localparam int unsigned REL_CYC = ns_to_cyc(T_REL_NS, CLK_PS);

   logic [NBANK-1:0] last_ce;
   logic             had_bank;
   logic [15:0]      idle_run;
   logic             all_hi;

   assign all_hi = (mem_ce_n == '1);

   // Counts cycles with every bank deselected since the last selection.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ce  <= '1;
         had_bank <= 1'b0;
         idle_run <= '0;
      end else begin
         if (all_hi) begin
            if (idle_run != 16'hFFFF) idle_run <= idle_run + 1'b1;
         end else begin
            idle_run <= '0;
            last_ce  <= mem_ce_n;
            had_bank <= 1'b1;
         end
      end
   end

   p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_ce_n) <= 1);

   p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !all_hi);

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_oe_ends_at_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (mem_oe_n && !$past(mem_oe_n)));

   p_release_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_hi && had_bank && (mem_ce_n != last_ce) && idle_run != 0) |-> (idle_run >= REL_CYC));

   p_no_direct_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_hi && had_bank && idle_run == 0) |-> (mem_ce_n == last_ce));

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_stable_under_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && !$past(mem_oe_n)) |-> ($stable(mem_addr) && $stable(mem_ce_n)));

endmodule

bind mbank_rd_ctrl mbank_rd_ctrl_chk #(
   .NBANK    (2 ** BANK_W),
   .ROW_W    (ADDR_W - BANK_W),
   .CLK_PS   (CLK_PS),
   .T_REL_NS (T_REL_NS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n)
);

// File: tb/mbank_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbank_rd_ctrl_tb_top;

   localparam int ADDR_W = 10;
   localparam int BANK_W = 2;
   localparam int DATA_W = 16;
   localparam int NBANK  = 4;
   localparam int ROW_W  = 8;
   localparam int ACC_CYC = (100 * 1000 + 3999) / 4000;  // 25
   localparam int OE_CYC  = (50 * 1000 + 3999) / 4000;   // 13
   localparam int REL_CYC = (45 * 1000 + 3999) / 4000;   // 12

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_ready;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic [ROW_W-1:0]  mem_addr;
   logic [NBANK-1:0]  mem_ce_n;
   logic              mem_oe_n;
   logic [DATA_W-1:0] mem_dq = 16'hBAD0;

   always #2 clk = ~clk;

   mbank_rd_ctrl #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
      .CLK_PS(4000), .T_ACC_NS(100), .T_OE_NS(50), .T_REL_NS(45)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pattern(input int bank, input int row);
      logic [15:0] v;
      v = 16'((bank * 256 + row) * 40503);
      return v ^ 16'h5A5A;
   endfunction

   function automatic int sel_bank(input logic [NBANK-1:0] ce);
      for (int i = 0; i < NBANK; i++) if (!ce[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // ---- memory model with real-time settle checks ----
   realtime t_chg = 0.0;
   realtime t_oe  = 0.0;
   always @(mem_addr or mem_ce_n) t_chg = $realtime;
   always @(negedge mem_oe_n) t_oe = $realtime;

   always @(negedge clk) begin
      realtime nxt;
      int b;
      nxt = $realtime + 2.0;
      b = sel_bank(mem_ce_n);
      if (b >= 0 && !mem_oe_n && (nxt - t_chg >= 100.0) && (nxt - t_oe >= 50.0))
         mem_dq = pattern(b, int'(mem_addr));
      else
         mem_dq = 16'hBAD0;
   end

   // ---- scoreboard ----
   typedef struct {
      logic [15:0] data;
      int          due;
      int          bank;
      int          row;
   } exp_t;
   exp_t sbq[$];

   bit open_v = 1'b0;
   int open_b = 0;

   task automatic do_read(input int bank, input int row);
      exp_t e;
      int lat;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(bank * 256 + row);
      @(posedge clk);
      #1;
      lat = (!open_v || open_b == bank) ? ACC_CYC : REL_CYC + ACC_CYC;
      e.data = pattern(bank, row);
      e.due  = cyc + lat;
      e.bank = bank;
      e.row  = row;
      sbq.push_back(e);
      open_v = 1'b1;
      open_b = bank;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // ---- monitor ----
   int oe_run = 0, oe_last = 0;
   int gap_run = 0, last_b = -1;
   bit oe_bad = 1'b0;

   always @(negedge clk) begin
      int b;
      if (rst_n && !done) begin
         if (!mem_oe_n) oe_run++;
         else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
         if (!mem_oe_n && mem_ce_n == '1) oe_bad = 1'b1;
         b = sel_bank(mem_ce_n);
         if (b < 0) gap_run++;
         else begin
            if (last_b >= 0 && b != last_b)
               check(gap_run >= REL_CYC, "R7", "deselect gap cycles", gap_run, REL_CYC);
            if (last_b >= 0 && b == last_b)
               check(gap_run == 0, "R6", "same-bank select dropped", gap_run, 0);
            last_b = b;
            gap_run = 0;
         end
         if (rd_valid) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R8", "unexpected rd_valid", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               check(rd_data == e.data, "R4", "read data", rd_data, e.data);
               check(cyc == e.due, "R4/R7 latency", "valid cycle", cyc, e.due);
               check(oe_last == OE_CYC && mem_oe_n, "R5", "oe low cycles", oe_last, OE_CYC);
               check(sel_bank(mem_ce_n) == e.bank && mem_addr == ROW_W'(e.row),
                     "R2", "bank/row", sel_bank(mem_ce_n), e.bank);
            end
         end
      end
   end

   // ---- watchdog ----
   initial begin
      #(200000 * 4);
      if (!done) begin
         check(1'b0, "WDOG", "watchdog expired", cyc, 0);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // ---- stimulus ----
   initial begin
      repeat (3) @(negedge clk);
      check(mem_ce_n == '1 && mem_oe_n && !rd_valid && req_ready, "R1", "reset outputs",
            {mem_ce_n, mem_oe_n, rd_valid, req_ready}, {4'hF, 3'b101});
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n == '1 && mem_oe_n && !rd_valid && req_ready, "R1", "after reset",
            {mem_ce_n, mem_oe_n, rd_valid, req_ready}, {4'hF, 3'b101});

      do_read(0, 8'h12);          // first access
      do_read(0, 8'h34);          // same bank R6
      do_read(2, 8'hFF);          // switch R7
      do_read(2, 8'h00);
      do_read(1, 8'h80);
      do_read(3, 8'h01);

      // R8: requests while busy are ignored
      do_read(3, 8'h05);
      repeat (2) @(negedge clk);
      for (int k = 0; k < 5; k++) begin
         req_valid = 1'b1;
         req_addr  = ADDR_W'(0 * 256 + 9);
         @(negedge clk);
         check(!req_ready, "R8", "ready while busy", req_ready, 0);
         check(mem_addr == 8'h05 && mem_ce_n == 4'b0111, "R8", "addr/ce held",
               {mem_ce_n, mem_addr}, {4'b0111, 8'h05});
      end
      req_valid = 1'b0;

      for (int k = 0; k < 8; k++) do_read((k * 3) % 4, (k * 37) % 256);
      do_read(1, 8'hAA);
      do_read(1, 8'h55);
      // idle: open bank select must stay low (R6)
      while (!req_ready || sbq.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      check(mem_ce_n == 4'b1101, "R6", "select held while idle", mem_ce_n, 4'b1101);
      check(!oe_bad, "R3", "oe low with no select", oe_bad, 0);
      check(sbq.size() == 0, "R4", "pending reads", sbq.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule